// File: doc/BRIEF.md
# Receive Status Word Queue with Peek and Pop Read Ports

This block sits between the receive side of a USB host controller and the processor. The packet engine pushes one status word for each receive event. Each word carries four fields: a packet status code, a data PID, an 11-bit byte count and a 4-bit channel number. The block queues these words in arrival order. Software reads them over a small register bus that has two windows onto the head of the queue. One window leaves the head in place. The other window returns the head and discards it in the same access.

A level flag tells software when at least one word is waiting, and popping is only meaningful while that flag is set. A read of either window while the queue is empty changes nothing and returns zero. A one-cycle event pulse marks each accepted push whose status code needs attention from the interrupt logic. A push that arrives while the queue is full is lost. The loss is recorded in a sticky flag that software clears by writing a one to it.

Top module: `rx_status_fifo_port`

## Requirements
- R1: A returned status word has bits 31:21 zero, the packet status in bits 20:17, the data PID in bits 16:15, the byte count in bits 14:4 and the channel number in bits 3:0.
- R2: A read at word address 0 (peek) returns the head word and leaves the queue contents and their order unchanged.
- R3: A read at word address 1 (pop) returns the head word and removes it, so that the next read returns the following entry.
- R4: A peek or pop while the queue is empty returns 32'h0000_0000 and does not change the queue state.
- R5: Output `rx_nonempty` is 1 exactly when at least one word is stored. It updates on the clock edge that accepts a push or a pop.
- R6: Words leave in the order they were pushed, and the queue holds up to DEPTH words (default 8).
- R7: A push while DEPTH words are stored is dropped, and it sets `rx_overflow`, which stays set.
- R8: A bus write to word address 2 with bit 1 set clears `rx_overflow`. A write there with bit 1 clear leaves it unchanged. A drop in the same cycle as a clear wins.
- R9: A push and a pop in the same cycle, with the queue neither empty nor full, both take effect and leave the entry count unchanged.
- R10: `irq_event` is high for one cycle after the edge that accepts a push whose status code is 4'b0011, 4'b0101 or 4'b0111. Code 4'b0010 and all reserved codes produce no pulse.
- R11: Read data is registered and appears on `bus_rdata` in the cycle after the read strobe. A read at word address 2 returns bit 0 = non-empty and bit 1 = overflow, with all other bits 0. A read at address 3 returns zero.
- R12: After reset the queue is empty, and `rx_overflow`, `irq_event` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Packet engine pushes one status word |
| push_pkt_sts | input | 4 | Packet status code of the pushed word |
| push_pid | input | 2 | Data PID (00 DATA0, 10 DATA1, 01 DATA2, 11 MDATA) |
| push_bcnt | input | 11 | Byte count of the received packet |
| push_chan | input | 4 | Channel number |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 peek, 1 pop, 2 flags |
| bus_wdata | input | 32 | Write data (bit 1 clears overflow at address 2) |
| bus_rdata | output | 32 | Registered read data |
| rx_nonempty | output | 1 | At least one status word stored |
| rx_overflow | output | 1 | Sticky flag: a push was dropped |
| irq_event | output | 1 | One-cycle pulse for an interrupt-worthy status code |

## Verification
A pointer that advances wrongly shows at the ports as a repeated word, a skipped word or an out-of-order word on the next pop. A wrong count shows as `rx_nonempty` disagreeing with the number of words pushed, or as the full limit arriving one entry early or late. Either symptom is visible within one read latency of the faulty edge. Field packing faults show on the first word read back, because the bench uses words whose fields all differ. Flag faults show on the cycle after the push or write that should have changed them.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int STS_W   = 4;
  localparam int PID_W   = 2;
  localparam int BCNT_W  = 11;
  localparam int CHAN_W  = 4;
  localparam int ENTRY_W = STS_W + PID_W + BCNT_W + CHAN_W;
  localparam int PAD_W   = WORD_W - ENTRY_W;

  localparam logic [ADDR_W-1:0] ADDR_PEEK = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_POP  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int STAT_NONEMPTY_BIT = 0;
  localparam int STAT_OVF_BIT      = 1;

  typedef enum logic [STS_W-1:0] {
    STS_IN_DATA   = 4'b0010,
    STS_IN_DONE   = 4'b0011,
    STS_TOGGLE_ER = 4'b0101,
    STS_CH_HALT   = 4'b0111
  } pkt_sts_e;

  // Field order inside the struct matches the word layout, MSB first.
  typedef struct packed {
    logic [STS_W-1:0]  sts;
    logic [PID_W-1:0]  pid;
    logic [BCNT_W-1:0] bcnt;
    logic [CHAN_W-1:0] chan;
  } rx_entry_t;

  function automatic logic [WORD_W-1:0] entry_to_word(input rx_entry_t e);
    return {{PAD_W{1'b0}}, e};
  endfunction

  function automatic logic code_wants_irq(input logic [STS_W-1:0] code);
    return (code == STS_IN_DONE) || (code == STS_TOGGLE_ER) || (code == STS_CH_HALT);
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic nonempty, input logic ovf);
    logic [WORD_W-1:0] w;
    w = '0;
    w[STAT_NONEMPTY_BIT] = nonempty;
    w[STAT_OVF_BIT]      = ovf;
    return w;
  endfunction

endpackage

// File: rtl/rxs_storage.sv
module rxs_storage #(
  parameter int DEPTH = 8,
  parameter int WIDTH = rxs_pkg::ENTRY_W,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head,
  output logic [PW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             wr_ok,
  output logic             pop_ok
);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PW-1:0]    wr_ptr;
  logic [PW-1:0]    rd_ptr;

  assign empty  = (wr_ptr == rd_ptr);
  assign full   = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign count  = wr_ptr - rd_ptr;
  assign wr_ok  = wr_req && !full;
  assign pop_ok = pop_req && !empty;
  assign head   = slot[rd_ptr[AW-1:0]];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[i] <= '0;
      end else if (wr_ok && (wr_ptr[AW-1:0] == AW'(i))) begin
        slot[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_ok)  wr_ptr <= wr_ptr + PW'(1);
      if (pop_ok) rd_ptr <= rd_ptr + PW'(1);
    end
  end

endmodule

// File: rtl/rxs_decode.sv
module rxs_decode
  import rxs_pkg::*;
(
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              peek_hit,
  output logic              pop_hit,
  output logic              stat_hit,
  output logic              ovf_clr
);

  assign peek_hit = bus_rd && (bus_addr == ADDR_PEEK);
  assign pop_hit  = bus_rd && (bus_addr == ADDR_POP);
  assign stat_hit = bus_rd && (bus_addr == ADDR_STAT);
  assign ovf_clr  = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[STAT_OVF_BIT];

endmodule

// File: rtl/rxs_flags.sv
module rxs_flags
  import rxs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_taken,
  input  logic             push_lost,
  input  logic [STS_W-1:0] push_code,
  input  logic             ovf_clr,
  output logic             overflow,
  output logic             irq_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow  <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= push_taken && code_wants_irq(push_code);
      if (push_lost)    overflow <= 1'b1;
      else if (ovf_clr) overflow <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_status_fifo_port.sv
module rx_status_fifo_port
  import rxs_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [STS_W-1:0]  push_pkt_sts,
  input  logic [PID_W-1:0]  push_pid,
  input  logic [BCNT_W-1:0] push_bcnt,
  input  logic [CHAN_W-1:0] push_chan,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              rx_nonempty,
  output logic              rx_overflow,
  output logic              irq_event
);

  // Named internal events, observed by the bound checker.
  rx_entry_t     in_entry;
  rx_entry_t     head_entry;
  logic [CW-1:0] fifo_count;
  logic          fifo_empty;
  logic          fifo_full;
  logic          push_ok;
  logic          pop_ok;
  logic          push_drop;
  logic          peek_hit;
  logic          pop_hit;
  logic          stat_hit;
  logic          ovf_clr;

  assign in_entry  = '{sts: push_pkt_sts, pid: push_pid, bcnt: push_bcnt, chan: push_chan};
  assign push_drop = push_valid && fifo_full;

  rxs_decode u_decode (
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .peek_hit  (peek_hit),
    .pop_hit   (pop_hit),
    .stat_hit  (stat_hit),
    .ovf_clr   (ovf_clr)
  );

  rxs_storage #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (push_valid),
    .wr_data (in_entry),
    .pop_req (pop_hit),
    .head    (head_entry),
    .count   (fifo_count),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .wr_ok   (push_ok),
    .pop_ok  (pop_ok)
  );

  rxs_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_taken (push_ok),
    .push_lost  (push_drop),
    .push_code  (push_pkt_sts),
    .ovf_clr    (ovf_clr),
    .overflow   (rx_overflow),
    .irq_pulse  (irq_event)
  );

  assign rx_nonempty = !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (peek_hit || pop_hit)
        bus_rdata <= fifo_empty ? '0 : entry_to_word(head_entry);
      else if (stat_hit)
        bus_rdata <= status_word(!fifo_empty, rx_overflow);
      else
        bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
  import rxs_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [CW-1:0]     fifo_count,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic              push_ok,
  input logic              pop_ok,
  input logic              rx_overflow,
  input logic              irq_event
);

  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADDR_PEEK || bus_addr == ADDR_POP) && fifo_empty)
      |=> (bus_rdata == '0));

  assert_peek_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_PEEK && !push_valid) |=> $stable(fifo_count));

  assert_pop_removes_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok) |=> (fifo_count == $past(fifo_count) - CW'(1)));

  assert_pushpop_same_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && push_ok) |=> $stable(fifo_count));

  assert_full_push_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && fifo_full) |=> rx_overflow);

  assert_irq_follows_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |-> $past(push_ok));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

endmodule

bind rx_status_fifo_port rxs_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_valid  (push_valid),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .fifo_count  (fifo_count),
  .fifo_empty  (fifo_empty),
  .fifo_full   (fifo_full),
  .push_ok     (push_ok),
  .pop_ok      (pop_ok),
  .rx_overflow (rx_overflow),
  .irq_event   (irq_event)
);

// File: tb/tb_rx_status_fifo_port.sv
module tb_rx_status_fifo_port;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [3:0]  push_pkt_sts = '0;
  logic [1:0]  push_pid = '0;
  logic [10:0] push_bcnt = '0;
  logic [3:0]  push_chan = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_nonempty;
  logic        rx_overflow;
  logic        irq_event;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] model_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_fifo_port #(.DEPTH(DEPTH)) dut (.*);

  function automatic logic [31:0] expect_word(int sts, int pid, int bcnt, int chan);
    return 32'(sts * 131072 + pid * 32768 + bcnt * 16 + chan);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(int sts, int pid, int bcnt, int chan, output logic irq_seen);
    @(negedge clk);
    push_valid = 1'b1; push_pkt_sts = 4'(sts); push_pid = 2'(pid);
    push_bcnt = 11'(bcnt); push_chan = 4'(chan);
    if (model_q.size() < DEPTH) model_q.push_back(expect_word(sts, pid, bcnt, chan));
    @(negedge clk);
    push_valid = 1'b0;
    irq_seen = irq_event;
  endtask

  task automatic bus_read(logic [1:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = addr;
    @(negedge clk);
    bus_rd = 1'b0;
    data = bus_rdata;
  endtask

  task automatic bus_write(logic [1:0] addr, logic [31:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic test_reset();
    check("R12 nonempty", 32'(rx_nonempty), 0);
    check("R12 overflow", 32'(rx_overflow), 0);
    check("R12 irq", 32'(irq_event), 0);
    check("R12 rdata", bus_rdata, 0);
  endtask

  task automatic test_empty_reads();
    logic [31:0] d;
    bus_read(2'd0, d); check("R4 empty peek", d, 0);
    bus_read(2'd1, d); check("R4 empty pop", d, 0);
    check("R4 still empty", 32'(rx_nonempty), 0);
    bus_read(2'd3, d); check("R11 unused addr", d, 0);
  endtask

  task automatic test_peek_layout();
    logic irq; logic [31:0] d;
    push(2, 2, 2047, 15, irq);
    check("R10 no irq for 0010", 32'(irq), 0);
    check("R5 nonempty after push", 32'(rx_nonempty), 1);
    bus_read(2'd0, d); check("R1 layout", d, 32'h0005_7FFF);
    bus_read(2'd0, d); check("R2 peek again", d, model_q[0]);
    bus_read(2'd2, d); check("R11 status reg", d, 32'h1);
  endtask

  task automatic test_irq_codes();
    logic irq;
    push(3, 0, 1, 1, irq);  check("R10 irq 0011", 32'(irq), 1);
    @(negedge clk);         check("R10 one cycle", 32'(irq_event), 0);
    push(5, 1, 64, 2, irq); check("R10 irq 0101", 32'(irq), 1);
    push(7, 3, 0, 3, irq);  check("R10 irq 0111", 32'(irq), 1);
    push(4, 0, 9, 4, irq);  check("R10 no irq reserved", 32'(irq), 0);
  endtask

  task automatic drain(string req);
    logic [31:0] d;
    while (model_q.size() > 0) begin
      bus_read(2'd1, d);
      check(req, d, model_q.pop_front());
    end
    check("R5 empty after drain", 32'(rx_nonempty), 0);
  endtask

  task automatic test_overflow();
    logic irq; logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) push(2, i % 4, 100 + i, i, irq);
    check("R7 no overflow at full", 32'(rx_overflow), 0);
    push(3, 0, 555, 9, irq);
    check("R7 overflow set", 32'(rx_overflow), 1);
    check("R7 dropped push no irq", 32'(irq), 0);
    bus_read(2'd2, d); check("R11 status ovf", d, 32'h3);
    drain("R6 order after full");
    bus_read(2'd1, d); check("R7 dropped word absent", d, 0);
    bus_write(2'd2, 32'h1);
    check("R8 write bit1=0 keeps", 32'(rx_overflow), 1);
    bus_write(2'd2, 32'h2);
    check("R8 w1c clears", 32'(rx_overflow), 0);
  endtask

  task automatic test_push_pop();
    logic irq; logic [31:0] d;
    push(2, 0, 10, 1, irq);
    push(2, 2, 20, 2, irq);
    @(negedge clk);
    push_valid = 1'b1; push_pkt_sts = 4'd3; push_pid = 2'd1;
    push_bcnt = 11'd30; push_chan = 4'd3;
    bus_rd = 1'b1; bus_addr = 2'd1;
    model_q.push_back(expect_word(3, 1, 30, 3));
    @(negedge clk);
    push_valid = 1'b0; bus_rd = 1'b0;
    check("R9 popped head", bus_rdata, model_q.pop_front());
    check("R9 irq on joint push", 32'(irq_event), 1);
    bus_read(2'd1, d); check("R9 second", d, model_q.pop_front());
    bus_read(2'd1, d); check("R9 third", d, model_q.pop_front());
    check("R9 count unchanged then empty", 32'(rx_nonempty), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_empty_reads();
    test_peek_layout();
    test_irq_codes();
    drain("R3 pop order");
    test_overflow();
    test_push_pop();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule